// File: doc/BRIEF.md
# Multichannel Conversion Channel Sequencer

This block picks the input channel that a converter samples on each serial transfer. It chooses among eight channels and tags every conversion result with the number of the channel it came from. One strobe per transfer delivers a decoded control word: a write-enable bit, a two-bit mode code (a sequence flag and a source flag) and a three-bit channel address. A separate port loads an eight-bit channel-enable mask. A stubbed converter supplies a 12-bit sample on the same strobe.

There are three ways to choose channels. In single mode one addressed channel is converted again and again. In masked-loop mode the enabled channels are visited in rising order and the walk wraps around. In counting-loop mode the block visits channel 0 up to the addressed channel and then starts again at channel 0.

A control word sent on one transfer takes effect from the next transfer. There are rules that keep a running loop intact when later transfers do not mean to stop it. The result of each transfer comes out as a registered 16-bit word with a one-cycle valid pulse.

Top module: `chan_seq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to single mode with channel 0 selected, `cur_chan` = 0 and `res_valid` = 0.
- R2: A transfer with `ctl_wr`=1 and mode code {`ctl_seq`,`ctl_shd`} = 00 or 01 selects single mode. The next transfer converts channel `ctl_addr`, and later transfers with `ctl_wr`=0 keep converting that same channel.
- R3: A transfer with `ctl_wr`=1 and mode code 10, sent while in single mode, starts the masked loop. Mask bit n enables channel n, and the next transfer converts the lowest enabled channel.
- R4: In the masked loop, each transfer is followed by the next higher enabled channel. After the highest enabled channel, the loop wraps to the lowest enabled channel.
- R5: A transfer with `ctl_wr`=1 and mode code 11 starts the counting loop with `ctl_addr` as its top. The next transfer converts channel 0, then 1, and so on up to the top, then channel 0 again. The mask has no effect in this mode.
- R6: A transfer with `ctl_wr`=0 leaves the mode and loop settings unchanged, whatever the other control fields hold. A running loop steps on as normal.
- R7: A transfer with `ctl_wr`=1 and mode code 10, sent while either loop is running, leaves that loop's kind, top and position unchanged. The loop steps on as if nothing had been written.
- R8: A running loop ends only through a control write with a mode code other than 10. Code 00 or 01 switches to single mode on `ctl_addr`. Code 11 restarts the counting loop at channel 0 with the new top.
- R9: A pulse on `mask_we` stores `mask_in`. If the masked loop is active, `cur_chan` moves to the lowest channel enabled in the new mask on the next cycle. In any other mode, `cur_chan` does not change.
- R10: In the masked loop with an all-zero mask, the block stays on channel 0 on every transfer.
- R11: One cycle after each `xfer` strobe, `res_valid` is high for exactly one cycle. `res_word` then holds bit 15 = 0, bits 14:12 = the channel converted on that transfer (the `cur_chan` value at the strobe), and bits 11:0 = the `samp_data` captured at the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer | input | 1 | One-cycle strobe marking a serial transfer |
| ctl_wr | input | 1 | Control word write-enable for this transfer |
| ctl_seq | input | 1 | Mode code, sequence flag |
| ctl_shd | input | 1 | Mode code, source flag |
| ctl_addr | input | 3 | Channel address or counting-loop top |
| mask_we | input | 1 | Channel-enable mask write strobe |
| mask_in | input | 8 | New channel-enable mask, bit n enables channel n |
| samp_data | input | 12 | Sample from the converter for this transfer |
| cur_chan | output | 3 | Channel to be converted on the next transfer |
| res_valid | output | 1 | Result word valid pulse |
| res_word | output | 16 | Result word: zero, channel, data |

## Verification
The bench targets the following corner cases and the wrong behaviour each one would expose:
- **Wrap point of the masked loop.** A design that wraps to channel 0 instead of the lowest enabled channel shows a channel field that never belongs to the mask.
- **Mode-10 write in the middle of a loop.** A design that treats it as a fresh start jumps back to the first channel and repeats channels.
- **Transfer with the write bit low.** The bench puts a single-mode code and an address on a transfer with the write bit low. A design that decodes it anyway drops out of the loop onto that address.
- **Mask reload and empty mask.** The bench reloads the mask mid-loop and runs the loop with an empty mask. A design that ignores the reload keeps walking the old pattern, and one that searches for a set bit with no escape hangs or gives a stray channel.

## Assertions and checks
Every result word is compared against an independent reference model of the channel order.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    CS_SINGLE = 2'd0,
    CS_MASKED = 2'd1,
    CS_COUNT  = 2'd2
  } cs_mode_e;
endpackage

// File: rtl/cs_mask_scan.sv
// Combinational search over the enable mask: lowest enabled channel and the
// first enabled channel strictly above the current one (wrapping to lowest).
module cs_mask_scan #(
  parameter int NCH = 8,
  parameter int AW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [AW-1:0]  cur,
  output logic [AW-1:0]  lowest,
  output logic [AW-1:0]  next_up,
  output logic           any_set
);
  logic [NCH-1:0] above;
  logic [AW-1:0]  above_pick;

  for (genvar g = 0; g < NCH; g++) begin : g_above
    assign above[g] = mask[g] && (AW'(g) > cur);
  end

  always_comb begin
    lowest = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) lowest = AW'(i);
    end
  end

  always_comb begin
    above_pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (above[i]) above_pick = AW'(i);
    end
  end

  assign any_set = |mask;
  assign next_up = (|above) ? above_pick : lowest;
endmodule

// File: rtl/cs_ctrl.sv
// Mode state, loop top, enable mask and the channel register.
module cs_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           xfer,
  input  logic           ctl_wr,
  input  logic           ctl_seq,
  input  logic           ctl_shd,
  input  logic [AW-1:0]  ctl_addr,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_in,
  output logic [AW-1:0]  cur_chan
);
  import cs_pkg::*;

  cs_mode_e       mode_q, mode_d;
  logic [AW-1:0]  top_q, top_d;
  logic [AW-1:0]  chan_d;
  logic [NCH-1:0] mask_q, eff_mask;
  logic [AW-1:0]  scan_low, scan_next;
  logic           scan_any;
  logic           keep_code, loop_on;

  assign eff_mask  = mask_we ? mask_in : mask_q;
  assign keep_code = ctl_seq && !ctl_shd;
  assign loop_on   = (mode_q != CS_SINGLE);

  cs_mask_scan #(.NCH(NCH), .AW(AW)) u_scan (
    .mask    (eff_mask),
    .cur     (cur_chan),
    .lowest  (scan_low),
    .next_up (scan_next),
    .any_set (scan_any)
  );

  always_comb begin
    mode_d = mode_q;
    top_d  = top_q;
    chan_d = cur_chan;
    if (xfer) begin
      if (ctl_wr && !keep_code) begin
        if (ctl_seq && ctl_shd) begin
          mode_d = CS_COUNT;
          top_d  = ctl_addr;
          chan_d = '0;
        end else begin
          mode_d = CS_SINGLE;
          chan_d = ctl_addr;
        end
      end else if (ctl_wr && !loop_on) begin
        mode_d = CS_MASKED;
        chan_d = scan_low;
      end else begin
        case (mode_q)
          CS_MASKED: chan_d = scan_any ? scan_next : '0;
          CS_COUNT:  chan_d = (cur_chan == top_q) ? '0 : cur_chan + AW'(1);
          default:   chan_d = cur_chan;
        endcase
      end
    end
    if (mask_we && mode_d == CS_MASKED) chan_d = scan_low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= CS_SINGLE;
      top_q    <= '0;
      mask_q   <= '0;
      cur_chan <= '0;
    end else begin
      mode_q   <= mode_d;
      top_q    <= top_d;
      cur_chan <= chan_d;
      if (mask_we) mask_q <= mask_in;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!xfer && !mask_we) |=> $stable(cur_chan)); // R2
  AST_MASK_MEMBER: assert property (@(posedge clk) disable iff (rst)
    (mode_q == CS_MASKED && |mask_q) |-> mask_q[cur_chan]); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (mode_q == CS_COUNT) |-> (cur_chan <= top_q)); // R5
  AST_NOWR_MODE: assert property (@(posedge clk) disable iff (rst)
    (xfer && !ctl_wr) |=> $stable(mode_q) && $stable(top_q)); // R6
  AST_KEEP_LOOP: assert property (@(posedge clk) disable iff (rst)
    (xfer && ctl_wr && keep_code && loop_on) |=> (mode_q == $past(mode_q)) && $stable(top_q)); // R7
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
    (mode_q == CS_MASKED && mask_q == '0) |-> (cur_chan == '0)); // R10
endmodule

// File: rtl/cs_pack.sv
// Registers the result word {0, channel, data} and its valid pulse.
module cs_pack #(
  parameter int AW = 3,
  parameter int DW = 12,
  parameter int WW = 1 + AW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer,
  input  logic [AW-1:0] chan,
  input  logic [DW-1:0] data,
  output logic          valid,
  output logic [WW-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      word  <= '0;
    end else begin
      valid <= xfer;
      if (xfer) word <= {1'b0, chan, data};
    end
  end
endmodule

// File: rtl/chan_seq_ctrl.sv
module chan_seq_ctrl #(
  parameter int NCH = 8,
  parameter int DW  = 12,
  localparam int AW = $clog2(NCH),
  localparam int WW = 1 + AW + DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           xfer,
  input  logic           ctl_wr,
  input  logic           ctl_seq,
  input  logic           ctl_shd,
  input  logic [AW-1:0]  ctl_addr,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_in,
  input  logic [DW-1:0]  samp_data,
  output logic [AW-1:0]  cur_chan,
  output logic           res_valid,
  output logic [WW-1:0]  res_word
);
  cs_ctrl #(.NCH(NCH), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .xfer     (xfer),
    .ctl_wr   (ctl_wr),
    .ctl_seq  (ctl_seq),
    .ctl_shd  (ctl_shd),
    .ctl_addr (ctl_addr),
    .mask_we  (mask_we),
    .mask_in  (mask_in),
    .cur_chan (cur_chan)
  );

  cs_pack #(.AW(AW), .DW(DW), .WW(WW)) u_pack (
    .clk   (clk),
    .rst   (rst),
    .xfer  (xfer),
    .chan  (cur_chan),
    .data  (samp_data),
    .valid (res_valid),
    .word  (res_word)
  );

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer |=> res_valid); // R11
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> !res_valid); // R11
  AST_WORD_CHAN: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (res_word[WW-2 -: AW] == $past(cur_chan)) && !res_word[WW-1]); // R11
  AST_WORD_DATA: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (res_word[DW-1:0] == $past(samp_data))); // R11
endmodule

// File: tb/tb_chan_seq_ctrl.sv
module tb_chan_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer = 1'b0, ctl_wr = 1'b0, ctl_seq = 1'b0, ctl_shd = 1'b0;
  logic [2:0]  ctl_addr = '0;
  logic        mask_we = 1'b0;
  logic [7:0]  mask_in = '0;
  logic [11:0] samp_data = '0;
  logic [2:0]  cur_chan;
  logic        res_valid;
  logic [15:0] res_word;

  int n_vec = 0, n_bad = 0, stim = 0;
  bit done = 0;

  // reference model: 0 single, 1 masked loop, 2 counting loop
  int       m_mode = 0;
  int       m_cur = 0, m_top = 0;
  bit [7:0] m_mask = '0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  chan_seq_ctrl dut (
    .clk(clk), .rst(rst), .xfer(xfer), .ctl_wr(ctl_wr), .ctl_seq(ctl_seq),
    .ctl_shd(ctl_shd), .ctl_addr(ctl_addr), .mask_we(mask_we), .mask_in(mask_in),
    .samp_data(samp_data), .cur_chan(cur_chan), .res_valid(res_valid), .res_word(res_word)
  );

  function automatic int first_on(bit [7:0] m, int from);
    for (int c = from; c < 8; c++) if (m[c]) return c;
    return -1;
  endfunction

  function automatic int low_on(bit [7:0] m);
    int r = first_on(m, 0);
    return (r < 0) ? 0 : r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_xfer(bit wr, bit sq, bit sh, int addr, string req);
    logic [11:0] d;
    int nx;
    @(negedge clk);
    stim++;
    d = 12'((stim * 613 + 91) % 4096);
    exp_q.push_back({1'b0, 3'(m_cur), d});
    tag_q.push_back(req);
    if (wr && !(sq && !sh)) begin
      if (sq && sh) begin m_mode = 2; m_top = addr; m_cur = 0; end
      else begin m_mode = 0; m_cur = addr; end
    end else if (wr && m_mode == 0) begin
      m_mode = 1; m_cur = low_on(m_mask);
    end else if (m_mode == 1) begin
      nx = first_on(m_mask, m_cur + 1);
      m_cur = (nx < 0) ? low_on(m_mask) : nx;
    end else if (m_mode == 2) begin
      m_cur = (m_cur >= m_top) ? 0 : m_cur + 1;
    end
    xfer = 1'b1; ctl_wr = wr; ctl_seq = sq; ctl_shd = sh;
    ctl_addr = 3'(addr); samp_data = d;
    @(negedge clk);
    xfer = 1'b0; ctl_wr = 1'b0;
  endtask

  task automatic load_mask(bit [7:0] m);
    @(negedge clk);
    m_mask = m;
    if (m_mode == 1) m_cur = low_on(m);
    mask_we = 1'b1; mask_in = m;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic chk_chan(string req);
    check(cur_chan == 3'(m_cur), req, int'(cur_chan), m_cur);
  endtask

  // monitor: pop expected words as results appear
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected word", int'(res_word), 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(res_word == e, t, int'(res_word), int'(e));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cur_chan == 3'd0, "R1 reset channel", int'(cur_chan), 0);
    check(res_valid == 1'b0, "R1 reset valid", int'(res_valid), 0);

    // single mode
    do_xfer(1, 0, 0, 5, "R2 write single");
    do_xfer(0, 0, 0, 0, "R2 single ch5");
    do_xfer(0, 1, 1, 2, "R6 wr low ignored");
    do_xfer(1, 0, 1, 3, "R8 code01 single");
    do_xfer(0, 0, 0, 0, "R2 single ch3");
    chk_chan("R2 holds ch3");

    // mask load outside masked loop
    load_mask(8'b1010_0100);
    chk_chan("R9 no move in single");

    // masked loop: 2,5,7,2,...
    do_xfer(1, 1, 0, 0, "R3 start masked");
    do_xfer(0, 0, 0, 0, "R3 lowest first");
    do_xfer(0, 0, 0, 1, "R6 wr low in loop");
    do_xfer(1, 1, 0, 6, "R7 code10 keeps loop");
    do_xfer(0, 0, 0, 0, "R4 wrap to lowest");
    do_xfer(0, 0, 0, 0, "R4 ascending");

    // mask reload inside loop
    load_mask(8'b0001_0010);
    chk_chan("R9 restart lowest");
    do_xfer(0, 0, 0, 0, "R9 new mask ch1");
    do_xfer(0, 0, 0, 0, "R9 new mask ch4");
    do_xfer(0, 0, 0, 0, "R4 new mask wrap");

    // counting loop
    do_xfer(1, 1, 1, 3, "R8 code11 ends mask loop");
    do_xfer(0, 0, 0, 0, "R5 count ch0");
    do_xfer(0, 0, 0, 0, "R5 count ch1");
    do_xfer(1, 1, 0, 0, "R7 code10 in count");
    do_xfer(0, 0, 0, 0, "R5 count top");
    do_xfer(0, 0, 0, 0, "R5 count wrap");
    do_xfer(1, 1, 1, 0, "R8 code11 restart");
    do_xfer(0, 0, 0, 0, "R5 top zero ch0");
    do_xfer(0, 0, 0, 0, "R5 top zero again");
    do_xfer(1, 0, 0, 6, "R8 code00 ends loop");
    do_xfer(0, 0, 0, 0, "R8 single ch6");

    // empty mask
    load_mask(8'h00);
    do_xfer(1, 1, 0, 4, "R10 start empty mask");
    do_xfer(0, 0, 0, 0, "R10 ch0");
    do_xfer(0, 0, 0, 0, "R10 ch0 hold");
    do_xfer(0, 0, 0, 0, "R10 ch0 hold again");
    chk_chan("R10 channel zero");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 words outstanding", exp_q.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule